// File: doc/BRIEF.md
# Prescaled Event Timestamp Timer

This block keeps a 16-bit time base for a processor subsystem. A counter advances by one on each tick of a power-of-two clock divider and wraps from all ones back to zero. A status bit records each wrap. After reset the time base is stopped to save power. Software starts it by setting an enable bit. A 3-bit divide code picks a tick rate from the bus clock divided by 1 up to the bus clock divided by 128. The wrap period is therefore 65536 ticks. For example, a 24 MHz clock with code 5 wraps roughly every 87.4 ms.

One capture input timestamps external events. The pin passes through a two-stage synchronizer. On the edge type that software selects, the current count is copied into a capture register and a capture flag is raised. Software measures an interval by subtracting two captured counts modulo 2^16 and multiplying by the tick period.

Access uses a simple word-wide register port. Writes are strobed and reads are combinational. Flags are cleared by writing a one to them.

Top module: `evt_stamp_timer`

## Requirements
- R1: After reset the count, enable bit, divide code, edge mode, both flags and the capture register are all zero, and the count holds until enabled.
- R2: Bit 7 of the run-control register (offset 0x06) enables the time base. While it is set, the count rises by exactly one per tick. While it is clear, both the divider and the count hold their values.
- R3: On the tick that takes the count from 0xFFFF to 0x0000, the overflow flag (bit 0 of the flag register at offset 0x0E) becomes set.
- R4: Bits 2:0 of the mode register (offset 0x0D) hold a divide code k, and ticks occur every 2^k enabled clocks. Code 0 gives a tick on every enabled clock.
- R5: A new divide code takes effect only when the internal 7-bit divider passes from 127 to 0. That divider advances once per enabled clock, so no tick is lost or doubled during a change.
- R6: Writing 1 to a flag bit at offset 0x0E clears that flag. Writing 0 leaves it unchanged. A flag that is set by an event in the same cycle as a clear stays set.
- R7: Bits 5:4 of the mode register select the capture edge: 00 none, 01 rising, 10 falling, 11 either. A qualifying edge, seen after a two-flop synchronizer, latches the count into the capture register (offset 0x10) and sets the capture flag (bit 1 of offset 0x0E).
- R8: The count is readable at offset 0x04 at any time. Undefined bits and unmapped offsets read as zero. Reads have no side effects.
- R9: Writes to the count register, to the capture register or to unmapped offsets change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| cap_pin | input | 1 | External event input, asynchronous |

## Verification
The bench drives the time base through a full wrap at divide-by-1. A design with an off-by-one wrap would raise the overflow flag one count early or late, or never. It changes the divide code in the middle of a divider period. A design that switched codes at once would give a short or doubled tick, and the count would drift against the reference. It pulses the capture pin in all four edge modes and clears flags in the same cycles as new events. Wrong edge polarity, a missing synchronizer stage or clear-over-set priority would each show up as a capture value or flag bit that differs from the model. It also writes to the count register and to unmapped offsets to show that nothing moves.

// File: rtl/evt_stamp_timer_pkg.sv
// Package: shared offsets, field positions and edge-mode encoding for the
// event timestamp timer. Assumes an 8-bit offset space and 16-bit data.
package evt_stamp_timer_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 16;

    localparam logic [ADDR_W-1:0] OFS_COUNT = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_RUN   = 8'h06;
    localparam logic [ADDR_W-1:0] OFS_MODE  = 8'h0D;
    localparam logic [ADDR_W-1:0] OFS_FLAGS = 8'h0E;
    localparam logic [ADDR_W-1:0] OFS_CAPT  = 8'h10;

    localparam int RUN_EN_BIT  = 7;
    localparam int EDGE_LSB    = 4;
    localparam int FLAG_OVF    = 0;
    localparam int FLAG_CAP    = 1;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_ANY  = 2'b11
    } edge_mode_e;

endpackage

// File: rtl/est_prescaler.sv
// Power-of-two tick divider. A free-running divider of (2^CODE_W - 1) bits
// advances on every enabled clock. The tick is high when the low k bits are
// all ones, where k is the active code. A requested code is copied into the
// active code only when the divider is all ones. All ratios share that
// boundary, so a change never shortens or repeats a tick period.
// Assumes run_en is synchronous to clk.
module est_prescaler #(
    parameter int CODE_W = 3,
    localparam int DIV_W = (1 << CODE_W) - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic [CODE_W-1:0] code_req,
    output logic              tick
);

    logic [DIV_W-1:0]  div_q;
    logic [CODE_W-1:0] code_act;
    logic [DIV_W-1:0]  mask;

    // Mask with the low code_act bits set, one comparator per bit.
    for (genvar gi = 0; gi < DIV_W; gi++) begin : g_mask
        assign mask[gi] = (CODE_W'(gi) < code_act);
    end

    // Tick when the selected low divider bits are all ones.
    always_comb tick = run_en && ((div_q & mask) == mask);

    // Advance the divider and pick up the new code at rollover.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q    <= '0;
            code_act <= '0;
        end else if (run_en) begin
            div_q <= div_q + 1'b1;
            if (&div_q) code_act <= code_req;
        end
    end

endmodule

// File: rtl/est_counter.sv
// Time-base counter with a wrap flag. It adds one on every tick and wraps
// naturally. The flag is set on the wrapping tick and cleared by a one-cycle
// clear pulse. Setting has priority over clearing.
// Assumes tick is already gated by the enable.
module est_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             ovf_clr,
    output logic [CNT_W-1:0] count,
    output logic             ovf_flag
);

    logic wrap;

    // The wrap happens on a tick taken while the count is all ones.
    always_comb wrap = tick && (&count);

    // Count ticks.
    always_ff @(posedge clk) begin
        if (!rst_n)    count <= '0;
        else if (tick) count <= count + 1'b1;
    end

    // Overflow flag: set wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)       ovf_flag <= 1'b0;
        else if (wrap)    ovf_flag <= 1'b1;
        else if (ovf_clr) ovf_flag <= 1'b0;
    end

endmodule

// File: rtl/est_capture.sv
// Single input-capture channel. The pin is resynchronized by SYNC_STAGES
// flops, and edges are detected against one more delayed copy. A qualifying
// edge latches the count and sets a flag. Setting beats a same-cycle clear.
// Assumes cap_pin may change at any time relative to clk.
module est_capture
    import evt_stamp_timer_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_pin,
    input  edge_mode_e       edge_sel,
    input  logic [CNT_W-1:0] count,
    input  logic             cap_clr,
    output logic [CNT_W-1:0] cap_val,
    output logic             cap_flag
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   rise, fall, hit;
    logic                   pin_s;

    always_comb pin_s = sync_q[SYNC_STAGES-1];

    // Synchronizer chain plus the delayed copy used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], cap_pin};
            prev_q <= pin_s;
        end
    end

    // Classify the edge and decide whether the selected mode takes it.
    always_comb begin
        rise = pin_s && !prev_q;
        fall = !pin_s && prev_q;
        unique case (edge_sel)
            EDGE_RISE: hit = rise;
            EDGE_FALL: hit = fall;
            EDGE_ANY:  hit = rise || fall;
            default:   hit = 1'b0;
        endcase
    end

    // Latch the count on a hit.
    always_ff @(posedge clk) begin
        if (!rst_n)   cap_val <= '0;
        else if (hit) cap_val <= count;
    end

    // Capture flag: set wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)       cap_flag <= 1'b0;
        else if (hit)     cap_flag <= 1'b1;
        else if (cap_clr) cap_flag <= 1'b0;
    end

endmodule

// File: rtl/est_regs.sv
// Register port: holds the run-enable bit, the divide code and the edge mode.
// It turns write-one-to-clear accesses into clear pulses and muxes the read
// data. Reads are combinational and have no side effects. Undefined bits and
// offsets read as zero.
module est_regs
    import evt_stamp_timer_pkg::*;
#(
    parameter int CODE_W = 3,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [CNT_W-1:0]  count,
    input  logic [CNT_W-1:0]  cap_val,
    input  logic              ovf_flag,
    input  logic              cap_flag,
    output logic              run_en,
    output logic [CODE_W-1:0] code_req,
    output edge_mode_e        edge_sel,
    output logic              ovf_clr,
    output logic              cap_clr
);

    logic wr_run, wr_mode, wr_flags;

    // Decode the write strobes.
    always_comb begin
        wr_run   = bus_wr && (bus_addr == OFS_RUN);
        wr_mode  = bus_wr && (bus_addr == OFS_MODE);
        wr_flags = bus_wr && (bus_addr == OFS_FLAGS);
        ovf_clr  = wr_flags && bus_wdata[FLAG_OVF];
        cap_clr  = wr_flags && bus_wdata[FLAG_CAP];
    end

    // Control register storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_en   <= 1'b0;
            code_req <= '0;
            edge_sel <= EDGE_OFF;
        end else begin
            if (wr_run) run_en <= bus_wdata[RUN_EN_BIT];
            if (wr_mode) begin
                code_req <= bus_wdata[CODE_W-1:0];
                edge_sel <= edge_mode_e'(bus_wdata[EDGE_LSB+1:EDGE_LSB]);
            end
        end
    end

    // Read multiplexer.
    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            OFS_COUNT: bus_rdata = DATA_W'(count);
            OFS_RUN:   bus_rdata[RUN_EN_BIT] = run_en;
            OFS_MODE: begin
                bus_rdata[CODE_W-1:0]            = code_req;
                bus_rdata[EDGE_LSB+1:EDGE_LSB]   = edge_sel;
            end
            OFS_FLAGS: begin
                bus_rdata[FLAG_OVF] = ovf_flag;
                bus_rdata[FLAG_CAP] = cap_flag;
            end
            OFS_CAPT:  bus_rdata = DATA_W'(cap_val);
            default:   bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/evt_stamp_timer.sv
// Top level of the prescaled event timestamp timer. It connects the register
// port, the tick divider, the time-base counter and the capture channel.
// Assumes a single clock domain except for cap_pin.
module evt_stamp_timer
    import evt_stamp_timer_pkg::*;
#(
    parameter int CODE_W      = 3,
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              cap_pin
);

    logic              run_en;
    logic [CODE_W-1:0] code_req;
    edge_mode_e        edge_sel;
    logic              ovf_clr, cap_clr;
    logic              tick;
    logic [CNT_W-1:0]  count;
    logic              ovf_flag;
    logic [CNT_W-1:0]  cap_val;
    logic              cap_flag;

    est_regs #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .count    (count),
        .cap_val  (cap_val),
        .ovf_flag (ovf_flag),
        .cap_flag (cap_flag),
        .run_en   (run_en),
        .code_req (code_req),
        .edge_sel (edge_sel),
        .ovf_clr  (ovf_clr),
        .cap_clr  (cap_clr)
    );

    est_prescaler #(.CODE_W(CODE_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_en  (run_en),
        .code_req(code_req),
        .tick    (tick)
    );

    est_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .ovf_clr (ovf_clr),
        .count   (count),
        .ovf_flag(ovf_flag)
    );

    est_capture #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_pin (cap_pin),
        .edge_sel(edge_sel),
        .count   (count),
        .cap_clr (cap_clr),
        .cap_val (cap_val),
        .cap_flag(cap_flag)
    );

endmodule

// File: rtl/evt_stamp_timer_chk.sv
// Checker for the event timestamp timer. It watches the top-level ports and
// the signals that pass between the submodules. It is attached by bind.
module evt_stamp_timer_chk
    import evt_stamp_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              run_en,
    input logic              tick,
    input logic [CNT_W-1:0]  count,
    input logic              ovf_flag,
    input logic              cap_flag,
    input logic [CNT_W-1:0]  cap_val
);

    logic unmapped;
    always_comb unmapped = !(bus_addr inside {OFS_COUNT, OFS_RUN, OFS_MODE, OFS_FLAGS, OFS_CAPT});

    // R2: no tick while disabled
    a_r2_no_tick_off: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |-> !tick);

    // R1: the count holds while disabled
    a_r1_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> $stable(count));

    // R2: a tick adds exactly one below the wrap point
    a_r2_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !(&count)) |=> (count == $past(count) + 1'b1));

    // R3: the wrapping tick yields zero and the overflow flag
    a_r3_wrap_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (&count)) |=> (count == '0) && ovf_flag);

    // R6: the overflow flag stays set unless written with a one
    a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !(bus_wr && bus_addr == OFS_FLAGS && bus_wdata[FLAG_OVF])) |=> ovf_flag);

    // R7: a newly raised capture flag comes with the prior count
    a_r7_cap_value: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cap_flag) |-> (cap_val == $past(count)));

    // R8: unmapped offsets read as zero
    a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        unmapped |-> (bus_rdata == '0));

endmodule

bind evt_stamp_timer evt_stamp_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .run_en   (run_en),
    .tick     (tick),
    .count    (count),
    .ovf_flag (ovf_flag),
    .cap_flag (cap_flag),
    .cap_val  (cap_val)
);

// File: tb/evt_stamp_timer_test.sv
// Bench: behavioural reference model stepped on each rising edge. The read
// data for the current offset is compared 2 ns after every edge.
module evt_stamp_timer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = 16'h0000;
    logic [15:0] bus_rdata;
    logic        cap_pin = 1'b0;

    int n_vec = 0;
    int n_bad = 0;
    int cycles = 0;
    string cur_req = "R1";

    // Reference model state.
    int m_en, m_code, m_act, m_div, m_cnt, m_ovf, m_capf, m_cap, m_edge;
    int pin_hist[3];

    evt_stamp_timer uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .cap_pin  (cap_pin)
    );

    always #5 clk = ~clk;

    task automatic model_reset();
        m_en = 0; m_code = 0; m_act = 0; m_div = 0; m_cnt = 0;
        m_ovf = 0; m_capf = 0; m_cap = 0; m_edge = 0;
        foreach (pin_hist[i]) pin_hist[i] = 0;
    endtask

    // Step the model at each rising edge from the inputs driven at the previous falling edge.
    always @(posedge clk) begin
        if (!rst_n) model_reset();
        else begin
            int ratio, tk, wrap, hit, rise, fall;
            ratio = 1 << m_act;
            tk    = (m_en != 0) && (((m_div + 1) % ratio) == 0);
            wrap  = tk && (m_cnt == 65535);
            rise  = pin_hist[1] && !pin_hist[2];
            fall  = !pin_hist[1] && pin_hist[2];
            hit   = (m_edge == 1 && rise) || (m_edge == 2 && fall) ||
                    (m_edge == 3 && (rise || fall));
            if (hit) m_cap = m_cnt;
            if (m_en != 0) begin
                if (m_div == 127) m_act = m_code;
                m_div = (m_div + 1) % 128;
            end
            if (tk) m_cnt = (m_cnt + 1) % 65536;
            if (bus_wr && bus_addr == 8'h0E) begin
                if (bus_wdata[0]) m_ovf = 0;
                if (bus_wdata[1]) m_capf = 0;
            end
            if (wrap) m_ovf = 1;
            if (hit)  m_capf = 1;
            if (bus_wr && bus_addr == 8'h06) m_en = bus_wdata[7];
            if (bus_wr && bus_addr == 8'h0D) begin
                m_code = bus_wdata[2:0];
                m_edge = bus_wdata[5:4];
            end
            pin_hist[2] = pin_hist[1];
            pin_hist[1] = pin_hist[0];
            pin_hist[0] = cap_pin;
        end
    end

    function automatic int expect_rd(input logic [7:0] a);
        case (a)
            8'h04:   return m_cnt;
            8'h06:   return m_en << 7;
            8'h0D:   return (m_edge << 4) | m_code;
            8'h0E:   return (m_capf << 1) | m_ovf;
            8'h10:   return m_cap;
            default: return 0;
        endcase
    endfunction

    // Compare away from the edge, on every cycle.
    always @(posedge clk) begin
        #2;
        cycles++;
        n_vec++;
        if (bus_rdata !== 16'(expect_rd(bus_addr))) begin
            n_bad++;
            $display("FAIL %s addr=%h actual=%h expected=%h t=%0t", cur_req, bus_addr,
                     bus_rdata, 16'(expect_rd(bus_addr)), $time);
        end
        if (cycles > 190000) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected<190000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = 16'h0000;
    endtask

    task automatic watch(input logic [7:0] a, input int n);
        @(negedge clk);
        bus_addr = a;
        repeat (n) @(negedge clk);
    endtask

    task automatic pin_to(input logic v, input int hold);
        @(negedge clk);
        cap_pin = v;
        repeat (hold) @(negedge clk);
    endtask

    initial begin
        // R1: reset state and hold while disabled
        cur_req = "R1";
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        watch(8'h04, 5); watch(8'h06, 2); watch(8'h0D, 2);
        watch(8'h0E, 2); watch(8'h10, 2);

        // R2: enable, count, then hold while disabled
        cur_req = "R2";
        wr(8'h06, 16'h0080);
        watch(8'h04, 20);
        wr(8'h06, 16'h0000);
        watch(8'h04, 10);
        wr(8'h06, 16'h0080);
        watch(8'h04, 10);

        // R4/R5: divide codes changed mid-period
        cur_req = "R4_R5";
        wr(8'h0D, 16'h0003);
        watch(8'h04, 300);
        wr(8'h0D, 16'h0007);
        watch(8'h04, 400);
        wr(8'h06, 16'h0000);
        watch(8'h04, 20);
        wr(8'h0D, 16'h0001);
        wr(8'h06, 16'h0080);
        watch(8'h04, 300);
        wr(8'h0D, 16'h0000);
        watch(8'h04, 200);

        // R7: rising edge mode
        cur_req = "R7";
        wr(8'h0D, 16'h0010);
        pin_to(1'b1, 6); watch(8'h10, 2); watch(8'h0E, 2);
        pin_to(1'b0, 6); watch(8'h10, 2);
        // R6: flag clear
        cur_req = "R6";
        wr(8'h0E, 16'h0002); watch(8'h0E, 3);
        wr(8'h0E, 16'h0000); watch(8'h0E, 2);
        // R7: falling, either, none
        cur_req = "R7";
        wr(8'h0D, 16'h0020);
        pin_to(1'b1, 8); watch(8'h10, 2);
        pin_to(1'b0, 8); watch(8'h10, 2); watch(8'h0E, 2);
        wr(8'h0D, 16'h0030);
        for (int i = 0; i < 4; i++) begin
            pin_to(1'(i % 2 == 0), 3 + i);
            watch(8'h10, 2);
        end
        wr(8'h0E, 16'h0002);
        wr(8'h0D, 16'h0000);
        pin_to(1'b1, 6); pin_to(1'b0, 6);
        watch(8'h10, 2); watch(8'h0E, 2);

        // R6: clears that collide with capture events in either-edge mode
        cur_req = "R6";
        wr(8'h0D, 16'h0030);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            cap_pin = ~cap_pin;
            bus_addr = 8'h0E; bus_wr = 1'b1; bus_wdata = 16'h0002;
            repeat (i) @(negedge clk);
            bus_wr = 1'b0;
            watch(8'h0E, 3);
        end

        // R8/R9: count writes and unmapped offsets
        cur_req = "R9";
        wr(8'h04, 16'h1234); watch(8'h04, 3);
        wr(8'h10, 16'hFFFF); watch(8'h10, 2);
        wr(8'h22, 16'hFFFF); watch(8'h06, 2); watch(8'h0D, 2);
        cur_req = "R8";
        watch(8'h00, 2); watch(8'h05, 2); watch(8'h0F, 2); watch(8'hFF, 2);

        // R3: full wrap at divide by 1
        cur_req = "R3";
        wr(8'h0D, 16'h0000);
        watch(8'h04, 65600);
        watch(8'h0E, 3);
        wr(8'h0E, 16'h0001);
        watch(8'h0E, 3);
        watch(8'h04, 5);

        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule